// File: doc/BRIEF.md
# Selectable-Edge Serial Echo Output

This block produces the serial data output of a quad-channel DAC core. Each bit taken from the data input on a rising serial-clock edge enters a 16-stage shift register. The bit leaving the far end of that register is presented on the output. A host can therefore read back the word it wrote on the previous transfer. Identical devices can also be chained, with each output feeding the next device's data input, so that a word passes through to the device behind.

The output can be launched on one of two serial-clock edges:

- **Falling-edge launch** (the default after clear). The output trails the input by sixteen and a half serial-clock periods. A half-period register holds each departing bit until the next falling edge.
- **Rising-edge launch.** The departing bit drives the output directly on the same rising edge, so the output trails the input by sixteen periods.

A mode bit from the command decoder selects the launch edge. That bit is taken in only while chip select is inactive, so the edge never changes inside a transfer.

All inputs arrive already synchronised to the system clock. The block detects serial-clock edges by comparing each sample with the one before it. A register updates on the first system-clock edge at which a serial-clock transition is visible. An active-low clear returns the block to its power-up state.

Top module: `dout_echo`

## Requirements
- R1: While `csN` is low, every rising `sclk` transition shifts `din` into the register. Words enter MSB first, and no other event moves the register.
- R2: In launch mode 0, `dout` changes only on falling `sclk` transitions. Counting the bits shifted in as b[0], b[1], …, after the falling transition that follows the k-th rising one, `dout` equals b[k-17], or 0 when k < 17. Between the k-th rise and the following fall it still shows b[k-18].
- R3: In launch mode 1, `dout` changes on rising `sclk` transitions. After the k-th rising transition it equals b[k-17], or 0 when k < 17, and it keeps that value through the following low phase.
- R4: While `rstN` is low, `dout` is 0, the register is emptied and launch mode 0 is selected. After release, bits shifted in before the clear never reappear on `dout`.
- R5: In every 16-bit transfer, the first bit launched on `dout` is the MSB of the previous transfer's word.
- R6: While `csN` is high, `sclk` and `din` activity has no effect. `dout` holds its value and the register contents are kept for the next transfer.
- R7: `modeSel` (0 = falling-edge launch, 1 = rising-edge launch) is taken in only while `csN` is high. A change of `modeSel` during a transfer takes effect only after `csN` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low clear, asynchronous assertion |
| sclk | input | 1 | Synchronised serial clock |
| csN | input | 1 | Synchronised active-low chip select |
| din | input | 1 | Synchronised serial data in |
| modeSel | input | 1 | Launch-edge select from the command decoder, 1 = rising |
| dout | output | 1 | Serial echo output |

## Verification
The hardest situation to create is a launch-mode request that changes while a transfer is in progress. The bench has to show that the edge stays put until chip select rises. To do this it flips `modeSel` in the middle of selected frames and checks `dout` in the high phase of each serial-clock period, which is the only phase where the two modes differ.

The retained launch mode after a clear is equally hidden, because any idle period reloads it. The bench therefore holds `csN` low across the clear with `modeSel` at 1, and checks that the following frame still behaves as falling-edge launch.

// File: rtl/dout_echo_pkg.sv
package dout_echo_pkg;

  // Strobes issued by the control to the datapath for one system clock
  typedef struct packed {
    logic shift;    // take din into the register
    logic launch;   // update the output flop
    logic useTail;  // launch from the half-period holding flop (falling mode)
  } echo_strobe_t;

endpackage

// File: rtl/dout_echo_ctrl.sv
module dout_echo_ctrl
  import dout_echo_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclk,
  input  logic         csN,
  input  logic         modeSel,
  output echo_strobe_t strb
);

  logic sclkPrev;
  logic activeMode;
  logic riseSeen;
  logic fallSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev   <= 1'b0;
      activeMode <= 1'b0;
    end else begin
      sclkPrev <= sclk;
      if (csN) activeMode <= modeSel;
    end
  end

  assign riseSeen = ~csN & sclk & ~sclkPrev;
  assign fallSeen = ~csN & ~sclk & sclkPrev;

  always_comb begin
    strb.shift   = riseSeen;
    strb.useTail = ~activeMode;
    strb.launch  = activeMode ? riseSeen : fallSeen;
  end

  // R7: the launch edge is frozen while a transfer is open
  assert_mode_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN)) |-> $stable(activeMode));

  // R2/R3: launches never coincide with a shift in falling mode
  assert_split_edges_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.launch && strb.useTail) |-> !strb.shift);

endmodule

// File: rtl/dout_echo_path.sv
module dout_echo_path
  import dout_echo_pkg::*;
#(
  parameter int WORD_BITS = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         din,
  input  echo_strobe_t strb,
  output logic         dout
);

  localparam int MSB = WORD_BITS - 1;

  logic [MSB:0] shReg;
  logic         tailBit;
  logic         outBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      tailBit <= 1'b0;
      outBit  <= 1'b0;
    end else begin
      if (strb.shift) begin
        shReg   <= {shReg[MSB-1:0], din};
        tailBit <= shReg[MSB];
      end
      if (strb.launch) outBit <= strb.useTail ? tailBit : shReg[MSB];
    end
  end

  assign dout = outBit;

  // R1: a shift takes the data input into the near end
  assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> shReg[0] == $past(din));

  // R3: rising launch drives the bit that is leaving the register
  assert_rise_launch_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.launch && !strb.useTail) |=> outBit == $past(shReg[MSB]));

  // R2: falling launch drives the bit held from the previous rise
  assert_fall_launch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.launch && strb.useTail) |=> outBit == $past(tailBit));

endmodule

// File: rtl/dout_echo.sv
module dout_echo #(
  parameter int WORD_BITS = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic din,
  input  logic modeSel,
  output logic dout
);
  import dout_echo_pkg::*;

  echo_strobe_t strb;

  dout_echo_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclk    (sclk),
    .csN     (csN),
    .modeSel (modeSel),
    .strb    (strb)
  );

  dout_echo_path #(.WORD_BITS(WORD_BITS)) u_path (
    .clk  (clk),
    .rstN (rstN),
    .din  (din),
    .strb (strb),
    .dout (dout)
  );

  // R6: with chip select high the output does not move
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> $stable(dout));

endmodule

// File: tb/dout_echo_bench.sv
module dout_echo_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic din = 1'b0;
  logic modeSel = 1'b0;
  logic dout;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  logic bits [0:4095];
  int   bitCount = 0;
  bit   curMode = 0;

  always #4 clk = ~clk;

  dout_echo u_dout_echo (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN),
    .din(din), .modeSel(modeSel), .dout(dout)
  );

  task automatic check(input string tag, input logic exp);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s: dout=%b expected %b (bit count %0d)", tag, dout, exp, bitCount);
    end
  endtask

  function automatic logic expAt(input int idx);
    return (idx < 0) ? 1'b0 : bits[idx];
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setMode(input bit m);
    modeSel = m;
    waitClk(2);
    curMode = m;
  endtask

  // One 16-bit transfer. flipAt >= 0 toggles modeSel mid-frame (R7).
  task automatic sendFrame(input logic [15:0] word, input string tag, input int flipAt);
    csN = 1'b0;
    waitClk(2);
    for (int i = 15; i >= 0; i--) begin
      din = word[i];
      waitClk(3);
      sclk = 1'b1;
      bits[bitCount] = word[i];
      bitCount++;
      waitClk(3);
      // high phase: mode 1 has launched (R3), mode 0 still old (R2)
      if (i == 15 && curMode) check("R5", expAt(bitCount - 17));
      else check(curMode ? "R3" : tag, curMode ? expAt(bitCount - 17) : expAt(bitCount - 18));
      if (i == flipAt) modeSel = ~modeSel;
      sclk = 1'b0;
      waitClk(3);
      if (i == 15 && !curMode) check("R5", expAt(bitCount - 17));
      else check(flipAt >= 0 ? "R7" : tag, expAt(bitCount - 17));
    end
    csN = 1'b1;
    waitClk(2);
    curMode = modeSel;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) bits[i] = 1'b0;
    waitClk(3);
    check("R4", 1'b0);
    rstN = 1'b1;
    waitClk(2);
    check("R4", 1'b0);

    // sweep of words and both launch modes
    for (int w = 0; w < 24; w++) begin
      logic [15:0] word;
      word = 16'(w * 16'h0B47) ^ 16'(w << 11) ^ 16'hA5C3;
      setMode(bit'(((w >> 1) ^ (w >> 2)) & 1));
      sendFrame(word, curMode ? "R3" : "R2", -1);
    end

    // R6: serial clock activity with chip select high is ignored
    begin
      logic held;
      held = dout;
      for (int i = 0; i < 8; i++) begin
        din = i[0]; sclk = 1'b1; waitClk(3);
        checks++; if (dout !== held) begin errors++; $display("FAIL R6: dout=%b expected %b", dout, held); end
        sclk = 1'b0; waitClk(3);
        checks++; if (dout !== held) begin errors++; $display("FAIL R6: dout=%b expected %b", dout, held); end
      end
    end
    setMode(1);
    sendFrame(16'h3C5A, "R6", -1);

    // R7: mode requests during a frame take effect only afterwards
    setMode(0);
    sendFrame(16'hF00F, "R7", 9);
    sendFrame(16'h1234, "R7", 4);
    sendFrame(16'h8001, "R7", 12);
    sendFrame(16'h7FFE, "R7", -1);

    // R4: clear mid-stream with csN low and modeSel=1; mode must be 0
    csN = 1'b0;
    modeSel = 1'b1;
    waitClk(2);
    rstN = 1'b0;
    waitClk(3);
    check("R4", 1'b0);
    rstN = 1'b1;
    bitCount = 0;
    curMode = 0;
    waitClk(2);
    sendFrame(16'hFFFF, "R4", -1);
    sendFrame(16'h0000, "R4", -1);
    sendFrame(16'hC0DE, "R5", -1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule